// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block performs the burn of a single one-time-programmable word once a program request has been accepted. On acceptance it latches the target word address, the requested data and the timing fields. It then reads the word currently stored in the fuse array and clears every requested bit that is already blown, so that no fuse is burned twice. The masked word is loaded into a data register that shifts right with zero fill. Bits are visited serially from bit 0 upward, and a program strobe is applied only for the 1 bits.

All interval lengths are counted in clock cycles. The timing inputs give the strobe length, the relax length and the read-strobe length. A relax field of zero still yields a one-cycle relax period. When the last bit has been visited, the block lowers its busy flag, emits a one-cycle done pulse, and keeps refusing new requests for a postamble whose length is a cycle-count parameter. The surrounding register decode presents a start pulse together with the operands. It must wait for the ready output before it issues the next request.

Top module: `fuse_burn_seq`

## Requirements
- R1: During and right after reset, busy_o, done_o and pgm_o are 0 and ready_o is 1.
- R2: A start_i sampled while ready_o is 1 is accepted, and busy_o is 1 in the next cycle. The address, data and timing values are captured on that edge, so later changes to addr_i, data_i or the timing inputs have no effect on the operation in progress.
- R3: The operation begins with a read phase that lasts tp_read_i + 2*(tp_relax_i + 1) cycles. During this phase fuse_rd_o is 1, fuse_addr_o carries the captured address and no strobe is issued. fuse_word_i is sampled in the last cycle of the phase.
- R4: The bits that are burned are data & ~fuse_word. A bit that is already 1 in the fuse word never receives a strobe, so the stored word ends up equal to its old value OR the requested data.
- R5: Bits are visited in order from bit 0 to bit WORD_W-1. pgm_bit_o gives the index of the bit being strobed and never decreases within an operation.
- R6: A bit to be burned takes tp_relax_i+1 relax cycles, then max(tp_prog_i,1) cycles with pgm_o at 1, then another tp_relax_i+1 relax cycles. A bit that is skipped takes exactly one cycle.
- R7: busy_o stays at 1 for the read phase plus the sum of the per-bit times. done_o is 1 for exactly the one cycle after the last bit, and busy_o falls on that same edge.
- R8: ready_o stays at 0 for POST_CYC cycles, counted from the done cycle. A start_i in that window is refused: busy_o stays at 0 and no fuse changes.
- R9: A start_i while busy_o is 1 is ignored. It does not extend the operation and does not change its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Program request pulse |
| addr_i | input | ADDR_W | Target fuse word address |
| data_i | input | WORD_W | Bits requested to be burned (1 = burn) |
| tp_prog_i | input | PROG_W | Program strobe length in cycles |
| tp_relax_i | input | RELAX_W | Relax length minus one, in cycles |
| tp_read_i | input | READ_W | Read strobe length in cycles |
| fuse_word_i | input | WORD_W | Current contents of the addressed fuse word |
| fuse_addr_o | output | ADDR_W | Fuse word address for the read and the burns |
| fuse_rd_o | output | 1 | Fuse read phase active |
| pgm_o | output | 1 | Program strobe for one fuse bit |
| pgm_bit_o | output | $clog2(WORD_W) | Index of the bit being strobed |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ready_o | output | 1 | A new request would be accepted |

## Verification
The bench builds the block with an 8-bit word, 3 address bits and a 5-cycle postamble. With these values every one of the 256 data patterns can be swept against several pre-blown fuse words, and each per-bit strobe count, each skip and the total busy length can be predicted arithmetically. Further runs at extreme timing values cover the zero relax and zero strobe fields, the largest relax and read values, and the full 12-bit strobe count. Every operation also sends a disturbing start while busy and another start during the postamble, and the bench then verifies that no other fuse word has changed.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_READ = 3'd1,
        S_SKIP = 3'd2,
        S_RLXA = 3'd3,
        S_STRB = 3'd4,
        S_RLXB = 3'd5,
        S_POST = 3'd6
    } fseq_state_e;

endpackage

// File: rtl/fseq_cnt.sv
module fseq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fseq_shreg.sv
module fseq_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         shift_i,
    output logic         lsb_o,
    output logic         nxt_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = val_i;
        end else if (shift_i) begin
            sr_d = {1'b0, sr_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign lsb_o = sr_q[0];
    assign nxt_o = sr_q[1];

endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
    import fseq_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int PROG_W   = 12,
    parameter int RELAX_W  = 4,
    parameter int READ_W   = 6,
    parameter int POST_CYC = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [WORD_W-1:0]         data_i,
    input  logic [PROG_W-1:0]         tp_prog_i,
    input  logic [RELAX_W-1:0]        tp_relax_i,
    input  logic [READ_W-1:0]         tp_read_i,
    input  logic [WORD_W-1:0]         fuse_word_i,
    output logic [ADDR_W-1:0]         fuse_addr_o,
    output logic                      fuse_rd_o,
    output logic                      pgm_o,
    output logic [$clog2(WORD_W)-1:0] pgm_bit_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      ready_o
);

    localparam int IDX_W   = $clog2(WORD_W);
    localparam int LAST    = WORD_W - 1;
    localparam int RD_SPAN = READ_W + RELAX_W + 2;
    localparam int PST_W   = $clog2(POST_CYC + 1);
    localparam int CW_A    = (PROG_W > RD_SPAN) ? PROG_W : RD_SPAN;
    localparam int CNT_W   = (CW_A > PST_W) ? CW_A : PST_W;

    typedef struct packed {
        fseq_state_e        st;
        logic [IDX_W-1:0]   bit_idx;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  data;
        logic [PROG_W-1:0]  prog;
        logic [RELAX_W-1:0] relax;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              cnt_ld;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              sh_ld;
    logic              sh_shift;
    logic [WORD_W-1:0] sh_val;
    logic              sh_lsb;
    logic              sh_nxt;
    logic              adv;

    fseq_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_ld),
        .val_i  (cnt_val),
        .zero_o (cnt_zero)
    );

    fseq_shreg #(.W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_ld),
        .val_i   (sh_val),
        .shift_i (sh_shift),
        .lsb_o   (sh_lsb),
        .nxt_o   (sh_nxt)
    );

    // Next-state computation for the whole sequencer.
    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        cnt_ld   = 1'b0;
        cnt_val  = '0;
        sh_ld    = 1'b0;
        sh_shift = 1'b0;
        sh_val   = ctl_q.data & ~fuse_word_i;
        adv      = 1'b0;

        unique case (ctl_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = S_READ;
                    ctl_d.addr  = addr_i;
                    ctl_d.data  = data_i;
                    ctl_d.prog  = tp_prog_i;
                    ctl_d.relax = tp_relax_i;
                    cnt_ld      = 1'b1;
                    // read strobe plus a relax period on each side, minus one
                    cnt_val     = CNT_W'(tp_read_i) + (CNT_W'(tp_relax_i) << 1)
                                + CNT_W'(1);
                end
            end
            S_READ: begin
                if (cnt_zero) begin
                    sh_ld         = 1'b1;
                    ctl_d.bit_idx = '0;
                    if (sh_val[0]) begin
                        ctl_d.st = S_RLXA;
                        cnt_ld   = 1'b1;
                        cnt_val  = CNT_W'(ctl_q.relax);
                    end else begin
                        ctl_d.st = S_SKIP;
                    end
                end
            end
            S_SKIP: begin
                adv = 1'b1;
            end
            S_RLXA: begin
                if (cnt_zero) begin
                    ctl_d.st = S_STRB;
                    cnt_ld   = 1'b1;
                    cnt_val  = (ctl_q.prog == '0) ? '0
                             : CNT_W'(ctl_q.prog) - CNT_W'(1);
                end
            end
            S_STRB: begin
                if (cnt_zero) begin
                    ctl_d.st = S_RLXB;
                    cnt_ld   = 1'b1;
                    cnt_val  = CNT_W'(ctl_q.relax);
                end
            end
            S_RLXB: begin
                if (cnt_zero) begin
                    adv = 1'b1;
                end
            end
            S_POST: begin
                if (cnt_zero) begin
                    ctl_d.st = S_IDLE;
                end
            end
            default: begin
                ctl_d.st = S_IDLE;
            end
        endcase

        // Move to the next bit, or finish after the top bit.
        if (adv) begin
            if (ctl_q.bit_idx == IDX_W'(LAST)) begin
                ctl_d.st   = S_POST;
                ctl_d.done = 1'b1;
                cnt_ld     = 1'b1;
                cnt_val    = CNT_W'(POST_CYC - 1);
            end else begin
                sh_shift      = 1'b1;
                ctl_d.bit_idx = ctl_q.bit_idx + IDX_W'(1);
                if (sh_nxt) begin
                    ctl_d.st = S_RLXA;
                    cnt_ld   = 1'b1;
                    cnt_val  = CNT_W'(ctl_q.relax);
                end else begin
                    ctl_d.st = S_SKIP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fuse_addr_o = ctl_q.addr;
    assign fuse_rd_o   = (ctl_q.st == S_READ);
    assign pgm_o       = (ctl_q.st == S_STRB);
    assign pgm_bit_o   = ctl_q.bit_idx;
    assign busy_o      = (ctl_q.st != S_IDLE) && (ctl_q.st != S_POST);
    assign done_o      = ctl_q.done;
    assign ready_o     = (ctl_q.st == S_IDLE);

    // Strobe state is only reachable with a 1 in the shift register LSB.
    logic unused_lsb;
    assign unused_lsb = sh_lsb;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic [ADDR_W-1:0]         fuse_addr_o,
    input logic                      fuse_rd_o,
    input logic                      pgm_o,
    input logic [$clog2(WORD_W)-1:0] pgm_bit_o,
    input logic                      busy_o,
    input logic                      done_o,
    input logic                      ready_o
);

    // R2: accepted request raises busy on the next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> busy_o);

    // R2: captured address holds for the whole operation
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));

    // R3: no strobe during the read phase
    p_read_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_rd_o |-> !pgm_o);

    // R5: a strobe run stays on one bit
    p_strobe_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_o && $past(pgm_o)) |-> (pgm_bit_o == $past(pgm_bit_o)));

    // R6: strobes only while busy
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_o |-> busy_o);

    // R7: done follows busy falling and lasts one cycle
    p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: nothing starts during the postamble
    p_post_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !busy_o) |=> !busy_o);

    // R1/R8: status outputs are mutually exclusive
    p_status_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o, ready_o}));

endmodule

bind fuse_burn_seq fseq_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_fseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fuse_addr_o (fuse_addr_o),
    .fuse_rd_o   (fuse_rd_o),
    .pgm_o       (pgm_o),
    .pgm_bit_o   (pgm_bit_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ready_o     (ready_o)
);

// File: tb/tb_fuse_burn_seq.sv
module tb_fuse_burn_seq;

    localparam int WW   = 8;
    localparam int AW   = 3;
    localparam int IW   = 3;
    localparam int POST = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [WW-1:0] data_i = '0;
    logic [11:0]   tp_prog_i = '0;
    logic [3:0]    tp_relax_i = '0;
    logic [5:0]    tp_read_i = '0;
    logic [WW-1:0] fuse_word_i;
    logic [AW-1:0] fuse_addr_o;
    logic          fuse_rd_o, pgm_o, busy_o, done_o, ready_o;
    logic [IW-1:0] pgm_bit_o;

    logic [WW-1:0] fuse_mem [0:7];

    int compared = 0;
    int mismatched = 0;
    int tot_cyc = 0;

    always #5 clk = ~clk;

    fuse_burn_seq #(
        .WORD_W(WW), .ADDR_W(AW), .PROG_W(12), .RELAX_W(4), .READ_W(6),
        .POST_CYC(POST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .data_i(data_i), .tp_prog_i(tp_prog_i), .tp_relax_i(tp_relax_i),
        .tp_read_i(tp_read_i), .fuse_word_i(fuse_word_i),
        .fuse_addr_o(fuse_addr_o), .fuse_rd_o(fuse_rd_o), .pgm_o(pgm_o),
        .pgm_bit_o(pgm_bit_o), .busy_o(busy_o), .done_o(done_o),
        .ready_o(ready_o)
    );

    // Fuse array model: combinational read, one bit blown per strobe cycle.
    assign fuse_word_i = fuse_mem[fuse_addr_o];
    always @(posedge clk) begin
        if (pgm_o) fuse_mem[fuse_addr_o][pgm_bit_o] <= 1'b1;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        tot_cyc++;
        if (tot_cyc > 190000) begin
            mismatched++;
            $display("FAIL watchdog act=%0d exp<=190000", tot_cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input int a, input int dat, input int old,
                          input int prog, input int relax, input int rd);
        logic [WW-1:0] masked;
        logic [WW-1:0] snap [0:7];
        int nr, eff, exp_busy, z, exp_fs, cyc, rdc, fs, lastbit, pc, other;
        int strobes [0:WW-1];

        masked = WW'(dat) & ~WW'(old);
        nr  = rd + 2 * (relax + 1);
        eff = (prog == 0) ? 1 : prog;
        exp_busy = nr;
        z = -1;
        for (int k = 0; k < WW; k++) begin
            strobes[k] = 0;
            if (masked[k]) begin
                exp_busy += 2 * (relax + 1) + eff;
                if (z < 0) z = k;
            end else begin
                exp_busy += 1;
            end
        end
        exp_fs = (z < 0) ? 0 : nr + z + relax + 2;
        other = (a + 2) % 8;

        @(negedge clk);
        fuse_mem[a] = WW'(old);
        for (int k = 0; k < 8; k++) snap[k] = fuse_mem[k];
        chk(ready_o == 1'b1, "R2 ready before start", ready_o, 1);
        start_i = 1'b1; addr_i = AW'(a); data_i = WW'(dat);
        tp_prog_i = 12'(prog); tp_relax_i = 4'(relax); tp_read_i = 6'(rd);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);

        cyc = 0; rdc = 0; fs = 0; lastbit = 0;
        while (busy_o) begin
            cyc++;
            if (fuse_rd_o) begin
                rdc++;
                if (fuse_addr_o != AW'(a))
                    chk(1'b0, "R3 read address", fuse_addr_o, a);
            end
            if (pgm_o) begin
                strobes[pgm_bit_o]++;
                if (fs == 0) fs = cyc;
                if (int'(pgm_bit_o) < lastbit)
                    chk(1'b0, "R5 bit order", pgm_bit_o, lastbit);
                lastbit = int'(pgm_bit_o);
            end
            // R2/R9: disturb operands and pulse start mid-operation
            if (cyc == 2) begin
                start_i = 1'b1; addr_i = AW'(a ^ 1); data_i = ~WW'(dat);
                tp_prog_i = 12'(prog + 3); tp_relax_i = 4'(relax ^ 1);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;

        chk(cyc == exp_busy, "R7 busy length", cyc, exp_busy);
        chk(rdc == nr, "R3 read length", rdc, nr);
        chk(fs == exp_fs, "R6 first strobe cycle", fs, exp_fs);
        for (int k = 0; k < WW; k++) begin
            chk(strobes[k] == (masked[k] ? eff : 0),
                $sformatf("R4 R6 strobes bit %0d", k), strobes[k], masked[k] ? eff : 0);
        end
        chk(done_o == 1'b1, "R7 done with busy fall", done_o, 1);
        chk(ready_o == 1'b0, "R8 not ready at done", ready_o, 0);

        // R8: request during postamble must be refused
        pc = 1;
        start_i = 1'b1; addr_i = AW'(other); data_i = '1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R7 done single cycle", done_o, 0);
        while (!ready_o && pc < 1000) begin
            pc++;
            if (busy_o) chk(1'b0, "R8 busy in postamble", busy_o, 0);
            @(negedge clk);
        end
        chk(pc == POST, "R8 postamble length", pc, POST);
        chk(busy_o == 1'b0, "R8 refused start idle", busy_o, 0);

        chk(fuse_mem[a] == (WW'(old) | WW'(dat)), "R4 fuse result",
            fuse_mem[a], WW'(old) | WW'(dat));
        for (int k = 0; k < 8; k++) begin
            if (k != a)
                chk(fuse_mem[k] == snap[k], "R9 R8 other word untouched",
                    fuse_mem[k], snap[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) fuse_mem[k] = WW'(k * 17);
        #1;
        // R1: reset values
        chk(busy_o == 1'b0 && done_o == 1'b0 && pgm_o == 1'b0,
            "R1 outputs in reset", {busy_o, done_o, pgm_o}, 0);
        chk(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && pgm_o == 1'b0 && ready_o == 1'b1,
            "R1 outputs after reset", {busy_o, done_o, pgm_o, ready_o}, 1);

        // Exhaustive data sweep against several pre-blown words, minimum timing
        for (int o = 0; o < 4; o++) begin
            int old;
            old = (o == 0) ? 8'h00 : (o == 1) ? 8'hA5 : (o == 2) ? 8'h3C : 8'hFF;
            for (int d = 0; d < 256; d++) begin
                run_op(d % 8, d, old, 1, 0, 0);
            end
        end

        // Timing extremes: zero fields, large relax and read, odd patterns
        for (int t = 0; t < 5; t++) begin
            int pg, rx, rdv;
            pg  = (t == 0) ? 0 : (t == 1) ? 3 : (t == 2) ? 5 : (t == 3) ? 40 : 2;
            rx  = (t == 0) ? 0 : (t == 1) ? 2 : (t == 2) ? 15 : (t == 3) ? 4 : 0;
            rdv = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 63 : (t == 3) ? 10 : 7;
            for (int p = 0; p < 5; p++) begin
                int dv;
                dv = (p == 0) ? 8'h01 : (p == 1) ? 8'h80 : (p == 2) ? 8'h81
                   : (p == 3) ? 8'hFF : 8'h5A;
                run_op((t + p) % 8, dv, 8'h0F, pg, rx, rdv);
            end
        end

        // Full-width strobe count
        run_op(5, 8'h80, 8'h00, 4095, 1, 3);

        summary();
        $finish;
    end

endmodule